// File: doc/BRIEF.md
# Character Reference Deletion-Mask Generator

This block watches an XML text stream one byte per cycle and marks, for every byte, what a later compaction stage must do with it. It does not rewrite text. For each byte it reports whether the byte belongs to the body of a named entity reference, a decimal character reference or a hexadecimal character reference. It also reports whether the byte is to be removed and whether it breaks the syntax of a reference. The semicolon that closes a reference is never marked for removal: it is the slot where the single replacement character will later be written. On the semicolon of a named reference the block also reports which of the five predefined entities was named, or that the name is some other one.

Bytes enter through a valid/ready handshake and leave through a single register stage with its own valid/ready handshake. The byte itself comes out together with its flags, one cycle after it is accepted, so the flags line up exactly with the positions of the text. A downstream stage can OR the delete flags with other deletion masks and apply them all in one pass.

Top module: `charref_delmask`

## Requirements
- R1: While reset is low, out_valid is 0 and in_ready is 1. Reset puts the scanner back into plain-text state, so a byte accepted after reset is judged as text even if a reference was open before reset.
- R2: A byte is accepted on a rising edge where in_valid and in_ready are both 1. On the next edge it appears on out_data with its flags and out_valid 1. in_ready is 0 only while out_valid is 1 and out_ready is 0. In that state every output holds its value.
- R3: A named reference is '&' (0x26) followed by name characters and then ';' (0x3B). Name characters are A-Z, a-z, 0-9, '_', '-', '.', ':' and any byte of 0x80 or above. out_gen is set on each name character. out_del is set on the '&' and on each name character. The ';' carries neither flag.
- R4: A decimal reference is "&#" followed by digits 0-9 and then ';'. out_dec is set on each digit. out_del is set on '&', '#' and each digit. The ';' is not deleted.
- R5: A hexadecimal reference is "&#x" (lower-case x only) followed by hex digits 0-9, a-f, A-F and then ';'. out_hex is set on each hex digit. out_del is set on '&', '#', 'x' and each hex digit. The ';' is not deleted.
- R6: out_ent is nonzero only on the ';' that closes a named reference. The codes are lt=1, gt=2, amp=3, apos=4, quot=5, and 7 for any other name. It is 0 on every other byte.
- R7: After '&', a byte that is neither a name character nor '#' gets out_err 1 and out_del 0. The '&' before it keeps out_del 1.
- R8: After "&#", a byte that is neither a digit nor 'x' (';' included) gets out_err 1 and is not deleted.
- R9: After "&#x", a byte that is not a hex digit (';' included) gets out_err 1 and is not deleted.
- R10: Once a reference body has begun, the only byte that may end it is ';'. This applies to decimal digits, hex digits and name characters. Any other byte that does not continue the body gets out_err 1 and is not deleted.
- R11: A numeric body holds at most MAX_DIGITS digits. A further digit or hex digit gets out_err 1 and is not deleted.
- R12: Outside a reference, every byte other than '&' has all flags 0. A byte that closes a reference (';') or is flagged in error ends the reference and opens nothing, even if it is '&'. Scanning then resumes in plain-text state with the next byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Block can take a byte this cycle |
| in_data | input | 8 | Input text byte |
| out_valid | output | 1 | Output position present |
| out_ready | input | 1 | Downstream takes the output position |
| out_data | output | 8 | The byte this position refers to |
| out_gen | output | 1 | Named-reference body character |
| out_dec | output | 1 | Decimal-reference digit |
| out_hex | output | 1 | Hexadecimal-reference digit |
| out_del | output | 1 | Byte to be removed by compaction |
| out_err | output | 1 | Malformed reference at this byte |
| out_ent | output | 3 | Entity code on a named reference's closing ';' |

## Verification
The bench builds the block with MAX_DIGITS set to 3 instead of the default 8. With that setting, references as short as "&#1234;" and "&#x1F2a;" hit the digit limit, and the random alphabet exceeds it often. Random in_valid gaps and out_ready stalls drive the hold behaviour of the output register throughout the run. A reset in the middle of an open numeric reference shows that the scanner's state is dropped.

// File: rtl/crd_pkg.sv
package crd_pkg;

    localparam int NUM_ENT    = 5;
    localparam int ENT_MAXLEN = 4;

    typedef enum logic [2:0] {
        ST_TEXT,
        ST_AMP,
        ST_HASH,
        ST_HEXX,
        ST_DEC,
        ST_HEXB,
        ST_NAME
    } scan_st_e;

    typedef struct packed {
        logic amp;
        logic hash;
        logic xch;
        logic semi;
        logic digit;
        logic hexd;
        logic namec;
    } cls_t;

    typedef struct packed {
        logic gen;
        logic dec;
        logic hex;
        logic del;
        logic err;
    } flags_t;

    localparam logic [2:0] ENT_NONE  = 3'd0;
    localparam logic [2:0] ENT_OTHER = 3'd7;

    // Packed spelling of each predefined name, first letter in the top byte.
    function automatic logic [31:0] ent_word(input int e);
        logic [31:0] w;
        case (e)
            0:       w = {"lt", 16'h0000};
            1:       w = {"gt", 16'h0000};
            2:       w = {"amp", 8'h00};
            3:       w = "apos";
            default: w = "quot";
        endcase
        return w;
    endfunction

    function automatic int ent_len(input int e);
        int n;
        case (e)
            0, 1:    n = 2;
            2:       n = 3;
            default: n = 4;
        endcase
        return n;
    endfunction

    function automatic logic [7:0] ent_char(input int e, input int i);
        logic [31:0] s;
        s = '0;
        if (i >= 0 && i < ENT_MAXLEN) begin
            s = ent_word(e) >> (8 * (ENT_MAXLEN - 1 - i));
        end
        return s[7:0];
    endfunction

endpackage

// File: rtl/crd_classify.sv
module crd_classify
    import crd_pkg::*;
(
    input  logic [7:0] ch,
    output cls_t       cls
);

    logic is_lower;
    logic is_upper;
    logic is_digit;

    always_comb begin
        is_lower = (ch >= 8'h61) && (ch <= 8'h7A);
        is_upper = (ch >= 8'h41) && (ch <= 8'h5A);
        is_digit = (ch >= 8'h30) && (ch <= 8'h39);

        cls.amp   = (ch == 8'h26);
        cls.hash  = (ch == 8'h23);
        cls.xch   = (ch == 8'h78);
        cls.semi  = (ch == 8'h3B);
        cls.digit = is_digit;
        cls.hexd  = is_digit
                  || ((ch >= 8'h61) && (ch <= 8'h66))
                  || ((ch >= 8'h41) && (ch <= 8'h46));
        cls.namec = is_lower || is_upper || is_digit
                  || (ch == 8'h5F) || (ch == 8'h2D)
                  || (ch == 8'h2E) || (ch == 8'h3A)
                  || ch[7];
    end

endmodule

// File: rtl/crd_entity.sv
module crd_entity
    import crd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step,
    input  logic       start,
    input  logic       cont,
    input  logic       finish,
    input  logic [7:0] ch,
    output logic [2:0] code
);

    localparam int IDX_MAX = ENT_MAXLEN + 1;
    localparam int IDX_W   = $clog2(IDX_MAX + 1);

    typedef struct packed {
        logic [NUM_ENT-1:0] alive;
        logic [IDX_W-1:0]   idx;
    } ent_st_t;

    ent_st_t            ent_d;
    ent_st_t            ent_q;
    logic [NUM_ENT-1:0] alive_nxt;
    logic [NUM_ENT-1:0] hit;

    // One candidate tracker per predefined name.
    genvar e;
    generate
        for (e = 0; e < NUM_ENT; e++) begin : g_cand
            always_comb begin
                if (start) begin
                    alive_nxt[e] = (ch == ent_char(e, 0));
                end else begin
                    alive_nxt[e] = ent_q.alive[e]
                                && (int'(ent_q.idx) < ent_len(e))
                                && (ch == ent_char(e, int'(ent_q.idx)));
                end
                hit[e] = ent_q.alive[e] && (int'(ent_q.idx) == ent_len(e));
            end
        end
    endgenerate

    always_comb begin
        ent_d = ent_q;
        if (step && (start || cont)) begin
            ent_d.alive = alive_nxt;
            if (start) begin
                ent_d.idx = IDX_W'(1);
            end else if (int'(ent_q.idx) < IDX_MAX) begin
                ent_d.idx = ent_q.idx + IDX_W'(1);
            end
        end

        code = ENT_NONE;
        if (finish) begin
            code = ENT_OTHER;
            for (int k = 0; k < NUM_ENT; k++) begin
                if (hit[k]) begin
                    code = 3'(k + 1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_q <= '0;
        end else begin
            ent_q <= ent_d;
        end
    end

endmodule

// File: rtl/crd_scan.sv
module crd_scan
    import crd_pkg::*;
#(
    parameter int MAX_DIGITS = 8
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   step,
    input  cls_t   cls,
    output flags_t flags,
    output logic   ent_start,
    output logic   ent_cont,
    output logic   ent_finish
);

    localparam int LEN_W = $clog2(MAX_DIGITS + 1);

    typedef struct packed {
        scan_st_e         st;
        logic [LEN_W-1:0] len;
    } scan_t;

    scan_t scan_d;
    scan_t scan_q;
    scan_t scan_n;
    logic  at_cap;

    always_comb begin
        scan_n     = scan_q;
        flags      = '0;
        ent_start  = 1'b0;
        ent_cont   = 1'b0;
        ent_finish = 1'b0;
        at_cap     = (scan_q.len >= LEN_W'(MAX_DIGITS));

        case (scan_q.st)
            ST_TEXT: begin
                if (cls.amp) begin
                    flags.del = 1'b1;
                    scan_n.st = ST_AMP;
                end
            end
            ST_AMP: begin
                if (cls.hash) begin
                    flags.del = 1'b1;
                    scan_n.st = ST_HASH;
                end else if (cls.namec) begin
                    flags.gen = 1'b1;
                    flags.del = 1'b1;
                    ent_start = 1'b1;
                    scan_n.st = ST_NAME;
                end else begin
                    flags.err = 1'b1;
                    scan_n.st = ST_TEXT;
                end
            end
            ST_HASH: begin
                if (cls.xch) begin
                    flags.del = 1'b1;
                    scan_n.st = ST_HEXX;
                end else if (cls.digit) begin
                    flags.dec  = 1'b1;
                    flags.del  = 1'b1;
                    scan_n.len = LEN_W'(1);
                    scan_n.st  = ST_DEC;
                end else begin
                    flags.err = 1'b1;
                    scan_n.st = ST_TEXT;
                end
            end
            ST_HEXX: begin
                if (cls.hexd) begin
                    flags.hex  = 1'b1;
                    flags.del  = 1'b1;
                    scan_n.len = LEN_W'(1);
                    scan_n.st  = ST_HEXB;
                end else begin
                    flags.err = 1'b1;
                    scan_n.st = ST_TEXT;
                end
            end
            ST_DEC: begin
                if (cls.semi) begin
                    scan_n.st = ST_TEXT;
                end else if (cls.digit && !at_cap) begin
                    flags.dec  = 1'b1;
                    flags.del  = 1'b1;
                    scan_n.len = scan_q.len + LEN_W'(1);
                end else begin
                    flags.err = 1'b1;
                    scan_n.st = ST_TEXT;
                end
            end
            ST_HEXB: begin
                if (cls.semi) begin
                    scan_n.st = ST_TEXT;
                end else if (cls.hexd && !at_cap) begin
                    flags.hex  = 1'b1;
                    flags.del  = 1'b1;
                    scan_n.len = scan_q.len + LEN_W'(1);
                end else begin
                    flags.err = 1'b1;
                    scan_n.st = ST_TEXT;
                end
            end
            ST_NAME: begin
                if (cls.semi) begin
                    ent_finish = 1'b1;
                    scan_n.st  = ST_TEXT;
                end else if (cls.namec) begin
                    flags.gen = 1'b1;
                    flags.del = 1'b1;
                    ent_cont  = 1'b1;
                end else begin
                    flags.err = 1'b1;
                    scan_n.st = ST_TEXT;
                end
            end
            default: begin
                scan_n.st = ST_TEXT;
            end
        endcase

        scan_d = step ? scan_n : scan_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scan_q <= '{st: ST_TEXT, len: '0};
        end else begin
            scan_q <= scan_d;
        end
    end

endmodule

// File: rtl/charref_delmask.sv
module charref_delmask
    import crd_pkg::*;
#(
    parameter int MAX_DIGITS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_data,
    output logic       out_valid,
    input  logic       out_ready,
    output logic [7:0] out_data,
    output logic       out_gen,
    output logic       out_dec,
    output logic       out_hex,
    output logic       out_del,
    output logic       out_err,
    output logic [2:0] out_ent
);

    typedef struct packed {
        logic       valid;
        logic [7:0] data;
        flags_t     flags;
        logic [2:0] ent;
    } out_st_t;

    out_st_t    o_d;
    out_st_t    o_q;
    cls_t       cls;
    flags_t     flags;
    logic       step;
    logic       ent_start;
    logic       ent_cont;
    logic       ent_finish;
    logic [2:0] ent_code;

    crd_classify u_cls (
        .ch  (in_data),
        .cls (cls)
    );

    crd_scan #(
        .MAX_DIGITS (MAX_DIGITS)
    ) u_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (step),
        .cls        (cls),
        .flags      (flags),
        .ent_start  (ent_start),
        .ent_cont   (ent_cont),
        .ent_finish (ent_finish)
    );

    crd_entity u_ent (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (step),
        .start  (ent_start),
        .cont   (ent_cont),
        .finish (ent_finish),
        .ch     (in_data),
        .code   (ent_code)
    );

    assign in_ready = !o_q.valid || out_ready;
    assign step     = in_valid && in_ready;

    always_comb begin
        o_d = o_q;
        if (step) begin
            o_d.valid = 1'b1;
            o_d.data  = in_data;
            o_d.flags = flags;
            o_d.ent   = ent_code;
        end else if (out_ready) begin
            o_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign out_valid = o_q.valid;
    assign out_data  = o_q.data;
    assign out_gen   = o_q.flags.gen;
    assign out_dec   = o_q.flags.dec;
    assign out_hex   = o_q.flags.hex;
    assign out_del   = o_q.flags.del;
    assign out_err   = o_q.flags.err;
    assign out_ent   = o_q.ent;

endmodule

// File: rtl/charref_delmask_chk.sv
module charref_delmask_chk #(
    parameter int MAX_DIGITS = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       in_ready,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_data,
    input logic       out_gen,
    input logic       out_dec,
    input logic       out_hex,
    input logic       out_del,
    input logic       out_err,
    input logic [2:0] out_ent
);

    localparam int RUN_MAX = MAX_DIGITS + 1;
    localparam int RUN_W   = $clog2(RUN_MAX + 1);

    logic [RUN_W-1:0] run_q;
    logic             is_hex_char;
    logic             is_dig_char;

    assign is_dig_char = (out_data >= 8'h30) && (out_data <= 8'h39);
    assign is_hex_char = is_dig_char
                       || ((out_data >= 8'h61) && (out_data <= 8'h66))
                       || ((out_data >= 8'h41) && (out_data <= 8'h46));

    // Length of the current run of numeric body digits handed downstream.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (out_valid && out_ready) begin
            if (out_dec || out_hex) begin
                if (int'(run_q) < RUN_MAX) begin
                    run_q <= run_q + RUN_W'(1);
                end
            end else begin
                run_q <= '0;
            end
        end
    end

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data)
            && $stable({out_gen, out_dec, out_hex, out_del, out_err, out_ent}));

    assert_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> out_valid);

    assert_span_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $onehot0({out_gen, out_dec, out_hex}));

    assert_semi_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_data == 8'h3B |-> !out_del && !out_gen);

    assert_span_del_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (out_gen || out_dec || out_hex) |-> out_del);

    assert_dec_digit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_dec |-> is_dig_char);

    assert_hex_digit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_hex |-> is_hex_char);

    assert_ent_semi_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ent != 3'd0 |-> out_data == 8'h3B && !out_err && out_ent != 3'd6);

    assert_err_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_err |-> !out_del && !out_gen && !out_dec && !out_hex);

    assert_cap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (out_dec || out_hex) |-> int'(run_q) < MAX_DIGITS);

endmodule

bind charref_delmask charref_delmask_chk #(
    .MAX_DIGITS (MAX_DIGITS)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_gen   (out_gen),
    .out_dec   (out_dec),
    .out_hex   (out_hex),
    .out_del   (out_del),
    .out_err   (out_err),
    .out_ent   (out_ent)
);

// File: tb/charref_delmask_tb_top.sv
module charref_delmask_tb_top;

    localparam int MAXD     = 3;
    localparam int WATCHDOG = 60000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid;
    logic       in_ready;
    logic [7:0] in_data;
    logic       out_valid;
    logic       out_ready;
    logic [7:0] out_data;
    logic       out_gen, out_dec, out_hex, out_del, out_err;
    logic [2:0] out_ent;

    always #4 clk = ~clk;

    charref_delmask #(.MAX_DIGITS(MAXD)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_gen(out_gen), .out_dec(out_dec), .out_hex(out_hex),
        .out_del(out_del), .out_err(out_err), .out_ent(out_ent)
    );

    int n_chk = 0;
    int n_err = 0;
    int cycles = 0;
    bit timeout = 0;
    bit r1_next = 0;

    logic [7:0]  src_q[$];
    logic [15:0] exp_q[$];
    string       tag_q[$];

    // Reference scanner state
    int          m_st;
    int          m_len;
    int          m_nlen;
    logic [39:0] m_name;

    function automatic bit f_dig(logic [7:0] b);
        return b >= "0" && b <= "9";
    endfunction
    function automatic bit f_hex(logic [7:0] b);
        return f_dig(b) || (b >= "a" && b <= "f") || (b >= "A" && b <= "F");
    endfunction
    function automatic bit f_name(logic [7:0] b);
        return f_dig(b) || (b >= "a" && b <= "z") || (b >= "A" && b <= "Z")
            || b == "_" || b == "-" || b == "." || b == ":" || b >= 8'h80;
    endfunction

    function automatic logic [15:0] outpack();
        return {out_data, out_gen, out_dec, out_hex, out_del, out_err, out_ent};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_st = 0; m_len = 0; m_nlen = 0; m_name = '0;
    endtask

    // States: 0 text, 1 after &, 2 after &#, 3 after &#x, 4 dec body, 5 hex body, 6 name
    task automatic model_byte(input logic [7:0] b, output logic [15:0] e, output string tag);
        logic g, d, h, dl, er;
        logic [2:0] ent;
        g = 0; d = 0; h = 0; dl = 0; er = 0; ent = 0; tag = "R12";
        case (m_st)
            0: if (b == "&") begin dl = 1; m_st = 1; tag = "R3"; end
            1: if (b == "#") begin dl = 1; m_st = 2; tag = "R4"; end
               else if (f_name(b)) begin
                   g = 1; dl = 1; m_st = 6; m_name = {32'h0, b}; m_nlen = 1; tag = "R3";
               end else begin er = 1; m_st = 0; tag = "R7"; end
            2: if (b == "x") begin dl = 1; m_st = 3; tag = "R5"; end
               else if (f_dig(b)) begin d = 1; dl = 1; m_len = 1; m_st = 4; tag = "R4"; end
               else begin er = 1; m_st = 0; tag = "R8"; end
            3: if (f_hex(b)) begin h = 1; dl = 1; m_len = 1; m_st = 5; tag = "R5"; end
               else begin er = 1; m_st = 0; tag = "R9"; end
            4, 5: begin
                if (b == ";") begin m_st = 0; tag = (m_st == 4) ? "R4" : "R5"; end
                else if ((m_st == 4) ? f_dig(b) : f_hex(b)) begin
                    if (m_len >= MAXD) begin er = 1; m_st = 0; tag = "R11"; end
                    else begin
                        if (m_st == 4) d = 1; else h = 1;
                        dl = 1; m_len++; tag = (m_st == 4) ? "R4" : "R5";
                    end
                end else begin er = 1; m_st = 0; tag = "R10"; end
            end
            default: begin
                if (b == ";") begin
                    ent = 3'd7;
                    if (m_nlen == 2 && m_name[15:0] == "lt") ent = 3'd1;
                    if (m_nlen == 2 && m_name[15:0] == "gt") ent = 3'd2;
                    if (m_nlen == 3 && m_name[23:0] == "amp") ent = 3'd3;
                    if (m_nlen == 4 && m_name[31:0] == "apos") ent = 3'd4;
                    if (m_nlen == 4 && m_name[31:0] == "quot") ent = 3'd5;
                    m_st = 0; tag = "R6";
                end else if (f_name(b)) begin
                    g = 1; dl = 1; m_name = {m_name[31:0], b};
                    if (m_nlen < 5) m_nlen++;
                    tag = "R3";
                end else begin er = 1; m_st = 0; tag = "R10"; end
            end
        endcase
        e = {b, g, d, h, dl, er, ent};
    endtask

    task automatic push_str(input string s);
        for (int i = 0; i < s.len(); i++) src_q.push_back(s[i]);
    endtask

    function automatic logic [7:0] rand_byte();
        logic [7:0] b;
        case ($urandom % 16)
            0, 1:    b = "&";
            2:       b = "#";
            3:       b = "x";
            4, 5:    b = 8'("0" + $urandom % 10);
            6:       b = 8'("a" + $urandom % 6);
            7:       begin
                         case ($urandom % 8)
                             0: b = "l"; 1: b = "t"; 2: b = "g"; 3: b = "a";
                             4: b = "m"; 5: b = "p"; 6: b = "q"; default: b = "u";
                         endcase
                     end
            8, 9:    b = ";";
            10:      b = " ";
            11:      b = ",";
            12:      b = "Z";
            13:      b = 8'hC3;
            14:      b = "o";
            default: b = 8'("A" + $urandom % 6);
        endcase
        return b;
    endfunction

    task automatic pump();
        bit          hold_pend;
        logic [15:0] hold_val;
        logic [15:0] e;
        string       t;
        hold_pend = 0;
        hold_val  = '0;
        while ((src_q.size() > 0 || exp_q.size() > 0) && !timeout) begin
            @(negedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                timeout = 1;
                check(0, "R2 watchdog", 16'(exp_q.size()), 16'h0);
                break;
            end
            if (hold_pend) begin
                check(out_valid && outpack() == hold_val, "R2 hold", outpack(), hold_val);
                hold_pend = 0;
            end
            out_ready = ($urandom % 4) != 0;
            in_valid  = (src_q.size() > 0) && (($urandom % 5) != 0);
            in_data   = (src_q.size() > 0) ? src_q[0] : 8'h00;
            #1;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(0, "R2 extra output", outpack(), 16'h0);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(outpack() == e, t, outpack(), e);
                end
            end else if (out_valid) begin
                hold_pend = 1;
                hold_val  = outpack();
            end
            if (in_valid && in_ready) begin
                model_byte(src_q.pop_front(), e, t);
                if (r1_next) begin t = "R1"; r1_next = 0; end
                exp_q.push_back(e);
                tag_q.push_back(t);
            end
        end
        @(negedge clk);
        in_valid = 0;
    endtask

    initial begin
        void'($urandom(32'd4711));
        rst_n = 0; in_valid = 0; in_data = 0; out_ready = 0;
        model_reset();
        repeat (3) @(negedge clk);
        #1;
        check(out_valid == 0 && in_ready == 1, "R1 reset",
              {15'h0, out_valid}, 16'h0);
        rst_n = 1;

        // Directed corner cases
        push_str("&gt; &#13; &#x0a; ");
        push_str("&#, &#x; &#; &; & &#xg ");
        push_str("&lt;&amp;&apos;&quot;&ltx;&gtt;&a; ");
        push_str("&#123;&#1234; &#x1F2;&#x1F2a; ");
        push_str("&#12a; &ab c &#xx; &&lt; &#x3E;; plain text;");
        // Random stream
        for (int i = 0; i < 2500; i++) src_q.push_back(rand_byte());
        pump();

        // Reset while a numeric reference is open
        push_str("&#1");
        pump();
        rst_n = 0;
        model_reset();
        @(negedge clk);
        #1;
        check(out_valid == 0 && in_ready == 1, "R1 mid-reset",
              {15'h0, out_valid}, 16'h0);
        rst_n = 1;
        r1_next = 1;
        push_str("2;");
        pump();

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule